// File: doc/BRIEF.md
# Dual-Source Clear-on-Read Interrupt Controller

This block drives one active-low interrupt line from two independent sources. The first source is a lookup result from the port side. It fires when a parsed packet's destination-address lookup has produced a result that software can read. The second source is a full indication from the system side, which reports that the address table has no free entry. Each source has its own enable bit, and the two bits live in separate configuration registers. Each source also keeps its own pending flag, so a source that is masked still records events.

The pending flags are cleared by reads, but a read only clears a flag once the condition behind it has gone away. For the result source, software reads every result word and then reads the result status. A status read made while words remain leaves the flag pending. For the table source, a read of the system status clears the flag only when the table is no longer full. Software can then read a status register to learn why the line is low.

Top module: `irq_dual_clr`

## Requirements
- R1: After reset, `irq_n` is 1, both pending flags are 0 and the remaining-word count is 0.
- R2: A 0-to-1 transition of `result_evt` sets the result pending flag and loads `result_words` into the remaining-word count. Holding `result_evt` high neither sets the flag again nor reloads the count.
- R3: Each cycle with `data_rd` high lowers the remaining-word count by one. The count stops at 0.
- R4: A cycle with `rstat_rd` high clears the result pending flag only if the remaining-word count is 0 at that clock edge. Otherwise the flag stays set.
- R5: A 0-to-1 transition of `full_lvl` sets the full pending flag.
- R6: A cycle with `sstat_rd` high clears the full pending flag only while `full_lvl` is 0. With `full_lvl` at 1 the flag stays set. The flag also stays set after `full_lvl` falls until such a read occurs.
- R7: `rstat` holds the result pending flag in its top bit and the remaining-word count in its lower CNT_W bits. In `sstat`, bit 0 is 0 while `full_lvl` is 1 and 1 otherwise, and bit 1 is the full pending flag.
- R8: `irq_n` is 0 exactly when the result flag is set with `port_en` high or the full flag is set with `sys_en` high. A masked flag stays visible in the status outputs.
- R9: A result event in the same cycle as `rstat_rd` leaves the flag set. A result event in the same cycle as `data_rd` loads the new count and the read is dropped. A `data_rd` and an `rstat_rd` in the same cycle use the count from before that edge, so the read of the last word does not also clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result_evt | input | 1 | Lookup result ready level; a rising edge marks a new result |
| result_words | input | CNT_W | Number of result words belonging to the new result |
| data_rd | input | 1 | Strobe: one result word was read |
| rstat_rd | input | 1 | Strobe: result status register read |
| port_en | input | 1 | Port-side enable for the result source |
| full_lvl | input | 1 | Table full level |
| sstat_rd | input | 1 | Strobe: system status register read |
| sys_en | input | 1 | System-side enable for the full source |
| irq_n | output | 1 | Active-low interrupt |
| rstat | output | CNT_W+1 | Result status: {pending, remaining words} |
| sstat | output | 2 | System status: {full pending, not full} |

## Verification
Several events can land on the same clock edge. A new result can arrive while software is still reading the result status or result words. The last-word read can fall in the same cycle as the status read. The bench drives each of these pairs in one cycle: a result edge with `rstat_rd`, a result edge with `data_rd`, `data_rd` with `rstat_rd` while one word remains, and a rising `full_lvl` with `sstat_rd`. For each pair, the scoreboard checks the status words and the interrupt line one edge later against the precedence stated in R9 and R5.

// File: rtl/irq_dual_clr_pkg.sv
package irq_dual_clr_pkg;
    localparam int NSRC     = 2;
    localparam int SRC_RES  = 0;
    localparam int SRC_FULL = 1;

    typedef struct packed {
        logic full_pend;
        logic not_full;
    } sys_stat_t;
endpackage

// File: rtl/irq_edge_rise.sv
module irq_edge_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irq_word_cnt.sv
module irq_word_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                   cnt_d = load_val;
        else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flag_d[i] = flag_q[i];
            if (set[i])      flag_d[i] = 1'b1;
            else if (clr[i]) flag_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_dual_clr.sv
module irq_dual_clr
    import irq_dual_clr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             result_evt,
    input  logic [CNT_W-1:0] result_words,
    input  logic             data_rd,
    input  logic             rstat_rd,
    input  logic             port_en,
    input  logic             full_lvl,
    input  logic             sstat_rd,
    input  logic             sys_en,
    output logic             irq_n,
    output logic [CNT_W:0]   rstat,
    output logic [1:0]       sstat
);
    logic [NSRC-1:0]  lvl, rise, set, clr, flag, en;
    logic [CNT_W-1:0] words_left;
    sys_stat_t        sys_w;

    always_comb begin
        lvl           = '0;
        lvl[SRC_RES]  = result_evt;
        lvl[SRC_FULL] = full_lvl;
    end

    irq_edge_rise #(.N(NSRC)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    irq_word_cnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rise[SRC_RES]),
        .load_val(result_words),
        .dec     (data_rd),
        .cnt     (words_left)
    );

    always_comb begin
        set           = rise;
        clr           = '0;
        clr[SRC_RES]  = rstat_rd && (words_left == '0);
        clr[SRC_FULL] = sstat_rd && !full_lvl;
        en            = '0;
        en[SRC_RES]   = port_en;
        en[SRC_FULL]  = sys_en;
    end

    irq_pend_flags #(.N(NSRC)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set),
        .clr  (clr),
        .flag (flag)
    );

    always_comb begin
        sys_w.full_pend = flag[SRC_FULL];
        sys_w.not_full  = !full_lvl;
        irq_n           = ~|(flag & en);
        rstat           = {flag[SRC_RES], words_left};
        sstat           = sys_w;
    end
endmodule

// File: rtl/irq_dual_clr_chk.sv
module irq_dual_clr_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             result_evt,
    input logic             data_rd,
    input logic             rstat_rd,
    input logic             port_en,
    input logic             full_lvl,
    input logic             sstat_rd,
    input logic             sys_en,
    input logic             irq_n,
    input logic [CNT_W:0]   rstat,
    input logic [1:0]       sstat
);
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_evt) |=> rstat[CNT_W]);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(result_evt) && data_rd && rstat[CNT_W-1:0] != '0)
        |=> (rstat[CNT_W-1:0] == $past(rstat[CNT_W-1:0]) - 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rstat_rd && rstat[CNT_W] && rstat[CNT_W-1:0] != '0) |=> rstat[CNT_W]);

    p_full_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_lvl) |=> sstat[1]);

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_lvl && sstat[1]) |=> sstat[1]);

    p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !sys_en) |-> irq_n);
endmodule

bind irq_dual_clr irq_dual_clr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .result_evt(result_evt),
    .data_rd   (data_rd),
    .rstat_rd  (rstat_rd),
    .port_en   (port_en),
    .full_lvl  (full_lvl),
    .sstat_rd  (sstat_rd),
    .sys_en    (sys_en),
    .irq_n     (irq_n),
    .rstat     (rstat),
    .sstat     (sstat)
);

// File: tb/tb_irq_dual_clr.sv
module tb_irq_dual_clr;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             result_evt = 1'b0;
    logic [CNT_W-1:0] result_words = '0;
    logic             data_rd = 1'b0;
    logic             rstat_rd = 1'b0;
    logic             port_en = 1'b0;
    logic             full_lvl = 1'b0;
    logic             sstat_rd = 1'b0;
    logic             sys_en = 1'b0;
    logic             irq_n;
    logic [CNT_W:0]   rstat;
    logic [1:0]       sstat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic           irq_n;
        logic [CNT_W:0] rstat;
        logic [1:0]     sstat;
        string          tag;
    } exp_t;

    exp_t scb[$];

    logic             m_pe, m_pf, m_res, m_full;
    logic [CNT_W-1:0] m_cnt;

    always #5 clk = ~clk;

    irq_dual_clr #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .result_evt(result_evt), .result_words(result_words),
        .data_rd(data_rd), .rstat_rd(rstat_rd), .port_en(port_en), .full_lvl(full_lvl),
        .sstat_rd(sstat_rd), .sys_en(sys_en), .irq_n(irq_n), .rstat(rstat), .sstat(sstat)
    );

    task automatic cmp(input string tag, input exp_t e);
        checks++;
        if (irq_n !== e.irq_n || rstat !== e.rstat || sstat !== e.sstat) begin
            errors++;
            $display("FAIL %s: irq_n=%b rstat=%h sstat=%b expected irq_n=%b rstat=%h sstat=%b",
                     tag, irq_n, rstat, sstat, e.irq_n, e.rstat, e.sstat);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result of that edge
    task automatic step(input logic evt, input logic [CNT_W-1:0] words, input logic drd,
                        input logic rrd, input logic pen, input logic full,
                        input logic srd, input logic sen, input string tag);
        logic rise_r, rise_f;
        exp_t e;
        @(posedge clk);
        #2;
        result_evt = evt; result_words = words; data_rd = drd; rstat_rd = rrd;
        port_en = pen; full_lvl = full; sstat_rd = srd; sys_en = sen;
        rise_r = evt & ~m_pe;
        rise_f = full & ~m_pf;
        if (rise_r)                  m_res = 1'b1;
        else if (rrd && m_cnt == 0)  m_res = 1'b0;
        if (rise_r)                  m_cnt = words;
        else if (drd && m_cnt != 0)  m_cnt = m_cnt - 1'b1;
        if (rise_f)                  m_full = 1'b1;
        else if (srd && !full)       m_full = 1'b0;
        m_pe = evt;
        m_pf = full;
        e.irq_n = !((m_res & pen) | (m_full & sen));
        e.rstat = {m_res, m_cnt};
        e.sstat = {m_full, !full};
        e.tag   = tag;
        scb.push_back(e);
    endtask

    // monitor: compare one expected item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (scb.size() > 0) cmp(scb[0].tag, scb.pop_front());
        end
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        m_pe = 0; m_pf = 0; m_res = 0; m_full = 0; m_cnt = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        r.irq_n = 1'b1; r.rstat = '0; r.sstat = 2'b01; r.tag = "R1 reset";
        cmp("R1 reset state", r);

        //   evt words drd rrd pen full srd sen
        step(0, 0, 0, 0, 1, 0, 0, 1, "R8 idle enabled");
        step(1, 3, 0, 0, 1, 0, 0, 1, "R2 result rise loads 3");
        step(1, 5, 0, 0, 1, 0, 0, 1, "R2 held level no reload");
        step(0, 0, 0, 1, 1, 0, 0, 1, "R4 status read with words left");
        step(0, 0, 1, 0, 1, 0, 0, 1, "R3 word read 3->2");
        step(0, 0, 1, 0, 1, 0, 0, 1, "R3 word read 2->1");
        step(0, 0, 1, 1, 1, 0, 0, 1, "R9 last word and status same cycle");
        step(0, 0, 0, 1, 1, 0, 0, 1, "R4 status read at zero clears");
        step(0, 0, 1, 0, 1, 0, 0, 1, "R3 read at zero saturates");
        step(0, 0, 0, 0, 1, 1, 0, 1, "R5 full rise");
        step(0, 0, 0, 0, 1, 1, 0, 1, "R7 bit0 low while full");
        step(0, 0, 0, 0, 1, 1, 1, 1, "R6 read while full keeps flag");
        step(0, 0, 0, 0, 1, 0, 0, 1, "R6 not full, no read keeps flag");
        step(0, 0, 0, 0, 1, 0, 0, 0, "R8 masked full flag still visible");
        step(0, 0, 0, 0, 1, 0, 1, 0, "R6 read when not full clears");
        step(1, 2, 0, 1, 1, 0, 0, 1, "R9 result rise with status read");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8 port mask hides result");
        step(1, 4, 1, 0, 1, 0, 0, 1, "R9 result rise with word read");
        step(0, 0, 0, 0, 1, 1, 1, 1, "R5 full rise with system read");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R8 both masked");
        step(0, 0, 1, 1, 1, 0, 0, 1, "R7 status layout after read");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule